// File: doc/BRIEF.md
# Idle Interval Timer with Tap-Bit Interrupt

This block is a free-running down-counter, 16 bits wide by default, that steps down by one on every instruction-cycle clock and never stops. Software has no way to read the count or load it. The block has one job. It watches a single fixed tap bit of the count, bit 12 by default. Every change of that bit, in either direction, is one timer event. With the defaults this happens once every 4096 clocks, which is about 4 ms at a 1 µs instruction cycle.

Each event is stored in a sticky pending flag. The flag stays set until a clear strobe arrives. An enable input gates the flag onto the interrupt request line. Each event also produces a one-cycle tick pulse, whatever the enable says. Low-power wake-up logic or a periodic scheduler can use that pulse. Reset loads zero into the counter so that runs are repeatable, but software must treat the count after power-up as unknown.

Top module: `idle_tmr`

## Requirements
- R1: While reset is asserted, the pending flag, the interrupt request and the tick pulse are all low, and the counter holds zero.
- R2: The counter decrements on every clock after reset, so tick pulses come exactly 2^TAP_BIT clocks apart (4096 by default). The first tick follows the first clock edge after reset, when the count goes from zero to all ones and the tap bit flips.
- R3: The tick pulse is high for exactly one clock per tap-bit change, whether the interrupt enable is high or low.
- R4: The pending flag is set on the same clock edge that raises the tick pulse.
- R5: Once set, the pending flag stays set until the clear strobe is high at a clock edge, and then it is low in the next cycle.
- R6: If the clear strobe is high on the same edge as a new tap-bit change, the pending flag stays set.
- R7: The interrupt request is high only when both the pending flag and the enable are high, in the same cycle. Dropping the enable removes the request but leaves the pending flag as it was.
- R8: The count wraps from zero to all ones with no break in the tick spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| pendClr | input | 1 | Strobe that clears the pending flag |
| intEn | input | 1 | Interrupt enable that gates the pending flag |
| pendFlag | output | 1 | Sticky event-pending flag |
| intReq | output | 1 | Interrupt request (pending AND enable) |
| tickPulse | output | 1 | One-cycle pulse on each tap-bit change |

## Verification
The bench builds the block with its default parameters: a 16-bit counter tapped at bit 12. At 4096 clocks per event, a run of about 65,500 cycles covers seventeen events and one full wrap of the counter through zero. Those defaults let the bench place a clear strobe on exactly the edge of an event. They also let it watch a tick arrive while the enable is low, and confirm that the event spacing does not move across the wrap.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

  // Strobes from the counter datapath to the event control
  typedef struct packed {
    logic tapFlip;   // tap bit changes on the coming clock edge
  } tmrEvt_t;

endpackage

// File: rtl/idle_tmr_dp.sv
module idle_tmr_dp
  import idle_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TAP_BIT = 12
) (
  input  logic    clk,
  input  logic    rst,
  output tmrEvt_t evt
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  generate
    if (TAP_BIT >= CNT_W) begin : g_badTap
      $error("TAP_BIT must index a bit inside the counter");
    end
  endgenerate

  // Down-count without pause; wrap from zero to all ones is natural
  assign cntNext = cnt - CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end

  // Tap bit differs between present and next value: an event on this edge
  always_comb begin
    evt = '0;
    evt.tapFlip = !rst && (cnt[TAP_BIT] ^ cntNext[TAP_BIT]);
  end

endmodule

// File: rtl/idle_tmr_ctl.sv
module idle_tmr_ctl
  import idle_tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  tmrEvt_t evt,
  input  logic    pendClr,
  input  logic    intEn,
  output logic    pendFlag,
  output logic    intReq,
  output logic    tickPulse
);

  logic pendQ;
  logic tickQ;
  logic pendD;

  // New event wins over a clear in the same cycle
  always_comb begin
    pendD = pendQ;
    if (pendClr)     pendD = 1'b0;
    if (evt.tapFlip) pendD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= 1'b0;
      tickQ <= 1'b0;
    end else begin
      pendQ <= pendD;
      tickQ <= evt.tapFlip;
    end
  end

  assign pendFlag  = pendQ;
  assign tickPulse = tickQ;
  assign intReq    = pendQ && intEn;

endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
  import idle_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TAP_BIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic pendClr,
  input  logic intEn,
  output logic pendFlag,
  output logic intReq,
  output logic tickPulse
);

  tmrEvt_t evt;

  idle_tmr_dp #(
    .CNT_W  (CNT_W),
    .TAP_BIT(TAP_BIT)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .evt(evt)
  );

  idle_tmr_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .pendClr  (pendClr),
    .intEn    (intEn),
    .pendFlag (pendFlag),
    .intReq   (intReq),
    .tickPulse(tickPulse)
  );

endmodule

// File: rtl/idle_tmr_chk.sv
module idle_tmr_chk #(
  parameter int CNT_W   = 16,
  parameter int TAP_BIT = 12
) (
  input logic clk,
  input logic rst,
  input logic pendClr,
  input logic intEn,
  input logic pendFlag,
  input logic intReq,
  input logic tickPulse
);

  localparam logic [TAP_BIT:0] GAP_LAST = {1'b0, {TAP_BIT{1'b1}}};
  localparam logic [TAP_BIT:0] GAP_ONE  = {{TAP_BIT{1'b0}}, 1'b1};

  logic [TAP_BIT:0] gapCnt;
  logic             seenTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      seenTick <= 1'b0;
    end else begin
      gapCnt   <= tickPulse ? '0 : gapCnt + GAP_ONE;
      if (tickPulse) seenTick <= 1'b1;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tickPulse && seenTick) |-> (gapCnt == GAP_LAST));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tickPulse |=> !tickPulse);

  // R4
  tick_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    tickPulse |-> pendFlag);

  // R4
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pendFlag) |-> tickPulse);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pendFlag && !pendClr) |=> pendFlag);

  // R5
  pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pendFlag) |-> $past(pendClr));

  // R6
  clr_vs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pendClr |=> (tickPulse || !pendFlag));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!intEn || !pendFlag) |-> !intReq);

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (intEn && pendFlag) |-> intReq);

endmodule

bind idle_tmr idle_tmr_chk #(
  .CNT_W  (CNT_W),
  .TAP_BIT(TAP_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pendClr  (pendClr),
  .intEn    (intEn),
  .pendFlag (pendFlag),
  .intReq   (intReq),
  .tickPulse(tickPulse)
);

// File: tb/idle_tmr_bench.sv
module idle_tmr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int END_CYC    = 65540;
  localparam int WDOG_CYC   = 150000;

  typedef struct {
    int    cyc;
    logic  tick;
    logic  pend;
    logic  irq;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pendClr = 1'b0;
  logic intEn = 1'b0;
  logic pendFlag, intReq, tickPulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tickSeen = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_tmr u_idle_tmr (
    .clk      (clk),
    .rst      (rst),
    .pendClr  (pendClr),
    .intEn    (intEn),
    .pendFlag (pendFlag),
    .intReq   (intReq),
    .tickPulse(tickPulse)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic checkBit(string req, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s cyc=%0d actual=%b expected=%b", req, what, cyc, act, expv);
    end
  endtask

  task automatic pushExp(int c, logic t, logic p, logic i, string req);
    expItem_t it;
    it.cyc = c; it.tick = t; it.pend = p; it.irq = i; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitCyc(int n);
    forever begin
      @(posedge clk);
      #1;
      if (cyc >= n) break;
    end
  endtask

  // Monitor: pop and compare expected items as their cycle arrives
  always @(negedge clk) begin
    if (!rst) begin
      if (tickPulse === 1'b1 && cyc <= 65537) tickSeen++;
      while (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        checkBit(it.req, "tickPulse", tickPulse, it.tick);
        checkBit(it.req, "pendFlag",  pendFlag,  it.pend);
        checkBit(it.req, "intReq",    intReq,    it.irq);
      end
    end
  end

  // Driver: expectations in cycle order, then stimulus
  initial begin
    pushExp(1,     1'b1, 1'b1, 1'b0, "R2");   // first flip 0 -> all ones
    pushExp(2,     1'b0, 1'b1, 1'b0, "R3");
    pushExp(100,   1'b0, 1'b1, 1'b1, "R7");   // enable raises request
    pushExp(200,   1'b0, 1'b1, 1'b1, "R5");   // clear not yet taken
    pushExp(201,   1'b0, 1'b0, 1'b0, "R5");
    pushExp(4096,  1'b0, 1'b0, 1'b0, "R2");
    pushExp(4097,  1'b1, 1'b1, 1'b1, "R4");
    pushExp(4098,  1'b0, 1'b1, 1'b1, "R3");
    pushExp(8192,  1'b0, 1'b1, 1'b1, "R6");
    pushExp(8193,  1'b1, 1'b1, 1'b1, "R6");   // clear loses to new event
    pushExp(8194,  1'b0, 1'b1, 1'b1, "R6");
    pushExp(9000,  1'b0, 1'b1, 1'b0, "R7");   // disable keeps pending
    pushExp(9101,  1'b0, 1'b0, 1'b0, "R5");
    pushExp(12289, 1'b1, 1'b1, 1'b0, "R3");   // tick with enable low
    pushExp(12290, 1'b0, 1'b1, 1'b0, "R3");
    pushExp(12300, 1'b0, 1'b1, 1'b1, "R7");
    pushExp(12401, 1'b0, 1'b0, 1'b0, "R7");   // enabled but not pending
    pushExp(65536, 1'b0, 1'b1, 1'b1, "R8");
    pushExp(65537, 1'b1, 1'b1, 1'b1, "R8");   // wrap keeps spacing

    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBit("R1", "pendFlag",  pendFlag,  1'b0);
    checkBit("R1", "intReq",    intReq,    1'b0);
    checkBit("R1", "tickPulse", tickPulse, 1'b0);
    @(posedge clk);
    #1 rst = 1'b0;

    waitCyc(100);   intEn = 1'b1;
    waitCyc(200);   pendClr = 1'b1;
    waitCyc(201);   pendClr = 1'b0;
    waitCyc(8192);  pendClr = 1'b1;
    waitCyc(8193);  pendClr = 1'b0;
    waitCyc(9000);  intEn = 1'b0;
    waitCyc(9100);  pendClr = 1'b1;
    waitCyc(9101);  pendClr = 1'b0;
    waitCyc(12300); intEn = 1'b1;
    waitCyc(12400); pendClr = 1'b1;
    waitCyc(12401); pendClr = 1'b0;
    waitCyc(END_CYC);
    @(negedge clk);

    // R2: one event per 4096 clocks, 17 events up to cycle 65537
    checks++;
    if (tickSeen != 17) begin
      failures++;
      $display("FAIL R2 tick count actual=%0d expected=17", tickSeen);
    end
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 unconsumed expectations actual=%0d expected=0", expQ.size());
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule